// File: doc/BRIEF.md
# Two-Clock Beat-Counting Delay Measurement Controller

This controller sequences a time-difference measurement built from two reference clocks whose periods differ by a tiny, known amount. The slightly faster clock is routed through a selectable signal path into the data pin of a capture flop. The slower clock, which is also the clock of this block, clocks that flop. A separate phase detector raises `sync_in` when the two clocks line up within a setup window. From that instant, the controller counts slow-clock edges until the capture output flips. The count times the period difference gives the total delay of the path, and that delay includes the capture flop's own setup time.

A measurement takes two legs. The first leg runs through the path that contains the delay under test, with `path_sel` = 0. The second leg runs through a bypass switch, with `path_sel` = 1. The controller reports both counts and their signed difference. The difference cancels the delay that the two paths share, so the remaining delay is the one under test plus the mismatch between the switches. An averaging mode repeats each leg 2^k times and reports the truncated mean of each leg. A programmable limit ends a count that never sees a transition and raises an overflow flag.

Top module: `vernier_meas`

## Requirements
- R1: While `rst` is high and after it is released, `done`, `ovf`, `path_sel`, `res_a`, `res_b` and `diff` are all zero.
- R2: A `start` pulse accepted in idle runs every leg-A repetition with `path_sel` = 0 first, and then every leg-B repetition with `path_sel` = 1. `path_sel` does not change while a count is running.
- R3: A run's count starts at the first clock edge that samples `sync_in` rising while the controller waits for alignment. If the first edge to sample the new `cap_in` level comes d edges later (d ≥ 1), the run's count is d+3. The three extra edges are two synchroniser stages, one stability sample and the compare.
- R4: A change of `cap_in` in either direction ends a run. The reference level is the filtered capture level at the alignment edge.
- R5: A `cap_in` pulse that lasts one clock is ignored, and counting goes on until a level has held for two samples.
- R6: When the count reaches the `timeout` value captured at start without a transition, the run stops with that count, and `ovf` is high with the next `done`. `ovf` clears for the following measurement.
- R7: `diff` is the 17-bit two's-complement value `res_a - res_b`, and it may be negative.
- R8: With `avg_k` = k at start, each leg runs 2^k times, and `res_a` / `res_b` equal the floor of the summed counts divided by 2^k.
- R9: `done` is high for exactly one cycle per measurement. The results become valid in that cycle and hold until the next `done`.
- R10: `start` has no effect while a measurement is in progress, so each accepted start yields exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a two-leg measurement (taken in idle only) |
| avg_k | input | K_W | log2 of repetitions per leg, clamped to MAX_K |
| timeout | input | CNT_W | Count limit per run, captured at start |
| sync_in | input | 1 | Clock-alignment pulse from the phase detector |
| cap_in | input | 1 | Asynchronous output of the capture flop |
| path_sel | output | 1 | 0 selects the path under test, 1 the bypass |
| res_a | output | CNT_W | Averaged count of leg A |
| res_b | output | CNT_W | Averaged count of leg B |
| diff | output | CNT_W+1 | Signed res_a minus res_b |
| ovf | output | 1 | A run in this measurement hit the limit |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench builds the block with its defaults: CNT_W = 16, MAX_K = 3 and two synchroniser stages. It drives `timeout` at run time. A limit of 15 makes the overflow stop reachable within a few dozen cycles. The rest of the measurements use a limit of 1000, so their counts end on a transition. Setting `avg_k` = 2 exercises four-run accumulation with truncation, and a short leg A against a long leg B produces a negative difference. One-cycle pulses on `cap_in` test the stability filter on both legs.

// File: rtl/vdm_pkg.sv
package vdm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_WAIT,
    ST_COUNT,
    ST_STORE,
    ST_DONE
  } vdm_state_e;
endpackage

// File: rtl/vdm_cap_filt.sv
module vdm_cap_filt #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_in,
  output logic lvl
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      lvl   <= 1'b0;
    end else begin
      chain <= {chain[STAGES-1:0], cap_in};
      if (chain[STAGES] == chain[STAGES-1])
        lvl <= chain[STAGES];
    end
  end

  // R5
  lvl_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl != $past(lvl)) |-> ($past(chain[STAGES-1]) == lvl && $past(chain[STAGES-1], 2) == lvl));
endmodule

// File: rtl/vdm_beat_cnt.sv
module vdm_beat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         at_lim
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc)
      cnt <= cnt + W'(1);
  end

  assign at_lim = (cnt == limit);

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (cnt != '0));
endmodule

// File: rtl/vdm_seq.sv
module vdm_seq
  import vdm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int MAX_K = 3,
  localparam int K_W   = $clog2(MAX_K + 1),
  localparam int REP_W = MAX_K + 1,
  localparam int ACC_W = CNT_W + MAX_K
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [K_W-1:0]          avg_k,
  input  logic [CNT_W-1:0]        timeout,
  input  logic                    sync_in,
  input  logic                    cap_lvl,
  input  logic [CNT_W-1:0]        cnt,
  input  logic                    at_lim,
  output logic                    cnt_clr,
  output logic                    cnt_inc,
  output logic [CNT_W-1:0]        tmo_q,
  output logic                    path_sel,
  output logic [CNT_W-1:0]        res_a,
  output logic [CNT_W-1:0]        res_b,
  output logic signed [CNT_W:0]   diff,
  output logic                    ovf,
  output logic                    done
);
  vdm_state_e       state;
  logic [K_W-1:0]   k_q;
  logic [K_W-1:0]   k_eff;
  logic [REP_W-1:0] rep;
  logic [REP_W-1:0] rep_last;
  logic [ACC_W-1:0] acc_a, acc_b;
  logic [ACC_W-1:0] sh_a, sh_b;
  logic [CNT_W-1:0] avg_a, avg_b;
  logic             ref_lvl, ovf_run, sync_q;
  logic             rise, changed;

  assign rise     = sync_in & ~sync_q;
  assign changed  = (cap_lvl != ref_lvl);
  assign rep_last = (REP_W'(1) << k_q) - REP_W'(1);
  assign k_eff    = (int'(avg_k) > MAX_K) ? K_W'(MAX_K) : avg_k;
  assign cnt_clr  = (state == ST_WAIT) && rise;
  assign cnt_inc  = (state == ST_COUNT) && !changed && !at_lim;

  always_comb begin
    sh_a  = acc_a >> k_q;
    sh_b  = acc_b >> k_q;
    avg_a = sh_a[CNT_W-1:0];
    avg_b = sh_b[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      k_q      <= '0;
      tmo_q    <= '0;
      rep      <= '0;
      acc_a    <= '0;
      acc_b    <= '0;
      ref_lvl  <= 1'b0;
      ovf_run  <= 1'b0;
      sync_q   <= 1'b0;
      path_sel <= 1'b0;
      res_a    <= '0;
      res_b    <= '0;
      diff     <= '0;
      ovf      <= 1'b0;
      done     <= 1'b0;
    end else begin
      sync_q <= sync_in;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            k_q      <= k_eff;
            tmo_q    <= timeout;
            rep      <= '0;
            acc_a    <= '0;
            acc_b    <= '0;
            ovf_run  <= 1'b0;
            path_sel <= 1'b0;
            state    <= ST_SELECT;
          end
        end
        ST_SELECT: state <= ST_WAIT;
        ST_WAIT: begin
          if (rise) begin
            ref_lvl <= cap_lvl;
            state   <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (changed) begin
            state <= ST_STORE;
          end else if (at_lim) begin
            ovf_run <= 1'b1;
            state   <= ST_STORE;
          end
        end
        ST_STORE: begin
          if (path_sel) acc_b <= acc_b + ACC_W'(cnt);
          else          acc_a <= acc_a + ACC_W'(cnt);
          if (rep == rep_last) begin
            rep <= '0;
            if (path_sel) begin
              state <= ST_DONE;
            end else begin
              path_sel <= 1'b1;
              state    <= ST_SELECT;
            end
          end else begin
            rep   <= rep + REP_W'(1);
            state <= ST_SELECT;
          end
        end
        ST_DONE: begin
          res_a <= avg_a;
          res_b <= avg_b;
          diff  <= {1'b0, avg_a} - {1'b0, avg_b};
          ovf   <= ovf_run;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  cnt_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT) |-> (cnt <= tmo_q));
  // R2
  path_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT) |-> $stable(path_sel));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  diff_match_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (diff == ({1'b0, res_a} - {1'b0, res_b})));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && start && !rise) |=> (state == ST_WAIT));
endmodule

// File: rtl/vernier_meas.sv
module vernier_meas #(
  parameter int CNT_W       = 16,
  parameter int MAX_K       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int K_W        = $clog2(MAX_K + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [K_W-1:0]        avg_k,
  input  logic [CNT_W-1:0]      timeout,
  input  logic                  sync_in,
  input  logic                  cap_in,
  output logic                  path_sel,
  output logic [CNT_W-1:0]      res_a,
  output logic [CNT_W-1:0]      res_b,
  output logic signed [CNT_W:0] diff,
  output logic                  ovf,
  output logic                  done
);
  logic             cap_lvl;
  logic             cnt_clr, cnt_inc, at_lim;
  logic [CNT_W-1:0] cnt, tmo_q;

  vdm_cap_filt #(.STAGES(SYNC_STAGES)) u_filt (
    .clk(clk), .rst(rst), .cap_in(cap_in), .lvl(cap_lvl)
  );

  vdm_beat_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .limit(tmo_q), .cnt(cnt), .at_lim(at_lim)
  );

  vdm_seq #(.CNT_W(CNT_W), .MAX_K(MAX_K)) u_seq (
    .clk(clk), .rst(rst), .start(start), .avg_k(avg_k), .timeout(timeout),
    .sync_in(sync_in), .cap_lvl(cap_lvl), .cnt(cnt), .at_lim(at_lim),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .tmo_q(tmo_q),
    .path_sel(path_sel), .res_a(res_a), .res_b(res_b), .diff(diff),
    .ovf(ovf), .done(done)
  );
endmodule

// File: tb/tb_vernier_meas.sv
module tb_vernier_meas;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int MAX_K = 3;
  localparam int K_W = $clog2(MAX_K + 1);

  typedef struct {
    logic [CNT_W-1:0] a;
    logic [CNT_W-1:0] b;
    logic [CNT_W:0]   d;
    logic             o;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [K_W-1:0] avg_k = '0;
  logic [CNT_W-1:0] timeout = '0;
  logic sync_in = 1'b0;
  logic cap_in = 1'b0;
  logic path_sel, ovf, done;
  logic [CNT_W-1:0] res_a, res_b;
  logic signed [CNT_W:0] diff;

  int n_chk = 0, n_bad = 0, n_done = 0, n_exp = 0;
  bit finished = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vernier_meas dut (
    .clk(clk), .rst(rst), .start(start), .avg_k(avg_k), .timeout(timeout),
    .sync_in(sync_in), .cap_in(cap_in), .path_sel(path_sel), .res_a(res_a),
    .res_b(res_b), .diff(diff), .ovf(ovf), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // one run: d=0 means no transition (timeout run)
  task automatic one_run(input int d, input bit glitch, input bit exp_path, input int tmo);
    @(negedge clk) sync_in = 1'b1;
    chk(path_sel == exp_path, "R2 path_sel at alignment", path_sel, exp_path);
    @(negedge clk) sync_in = 1'b0;
    if (d > 0) begin
      for (int i = 1; i < d; i++) begin
        @(negedge clk);
        if (glitch && (i == 1 || i == 2)) cap_in = ~cap_in;
      end
      cap_in = ~cap_in;
      repeat (12) @(negedge clk);
    end else begin
      repeat (tmo + 12) @(negedge clk);
    end
  endtask

  // driver: pushes the expected result, then drives the two legs
  task automatic measure(input int k, input int tmo, input int da[4], input int db[4],
                         input bit glitch, input bit poke_start, input string tag);
    exp_t e;
    int sa = 0, sb = 0, nr;
    bit o = 0;
    nr = 1 << k;
    for (int i = 0; i < nr; i++) begin
      sa += (da[i] == 0) ? tmo : da[i] + 3;
      sb += (db[i] == 0) ? tmo : db[i] + 3;
      if (da[i] == 0 || db[i] == 0) o = 1;
    end
    e.a = CNT_W'(sa >> k);
    e.b = CNT_W'(sb >> k);
    e.d = (CNT_W+1)'((sa >> k) - (sb >> k));
    e.o = o;
    e.tag = tag;
    q.push_back(e);
    n_exp++;
    @(negedge clk);
    avg_k = K_W'(k);
    timeout = CNT_W'(tmo);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    if (poke_start) begin
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    for (int i = 0; i < nr; i++) one_run(da[i], glitch, 1'b0, tmo);
    for (int i = 0; i < nr; i++) one_run(db[i], glitch, 1'b1, tmo);
    repeat (4) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    logic [CNT_W-1:0] ha, hb;
    bit follow = 0;
    forever begin
      @(negedge clk);
      if (follow) begin
        chk(done == 1'b0, "R9 done width", done, 0);
        chk(res_a == ha && res_b == hb, "R9 results held", res_a, ha);
        follow = 0;
      end
      if (!rst && done) begin
        n_done++;
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected done", n_done, n_exp);
        end else begin
          e = q.pop_front();
          chk(res_a == e.a, {e.tag, " res_a"}, res_a, e.a);
          chk(res_b == e.b, {e.tag, " res_b"}, res_b, e.b);
          chk(diff == e.d, {e.tag, " R7 diff"}, diff, $signed(e.d));
          chk(ovf == e.o, {e.tag, " R6 ovf"}, ovf, e.o);
          ha = res_a;
          hb = res_b;
          follow = 1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_done, n_exp);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(done == 0 && ovf == 0, "R1 flags in reset", {done, ovf}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(path_sel == 0, "R1 path_sel", path_sel, 0);
    chk(res_a == 0 && res_b == 0, "R1 results", res_a + res_b, 0);
    chk(diff == 0, "R1 diff", diff, 0);
    chk(done == 0 && ovf == 0, "R1 flags", {done, ovf}, 0);
    // R3 R4: plain counts, both capture polarities
    measure(0, 1000, '{30, 0, 0, 0}, '{10, 0, 0, 0}, 0, 0, "R3 R4 plain");
    // R7 negative difference, R10 start during a run
    measure(0, 1000, '{2, 0, 0, 0}, '{20, 0, 0, 0}, 0, 1, "R7 R10 negative");
    // R6 timeout on leg A
    measure(0, 15, '{0, 0, 0, 0}, '{4, 0, 0, 0}, 0, 0, "R6 timeout");
    // R8 averaging over four runs per leg, also R6 ovf cleared
    measure(2, 1000, '{5, 6, 7, 9}, '{1, 1, 2, 2}, 0, 0, "R8 R6 average");
    // R5 one-cycle pulses rejected
    measure(0, 1000, '{8, 0, 0, 0}, '{6, 0, 0, 0}, 1, 0, "R5 glitch");
    repeat (20) @(negedge clk);
    chk(n_done == n_exp && q.size() == 0, "R10 done count", n_done, n_exp);
    summary();
  end
endmodule